// File: doc/BRIEF.md
# PCIe Function Error Classifier

This block takes one detected error event per cycle and decides how a PCIe function records and reports it. Each event carries a single-bit status code, a flag that marks it as correctable, a flag that allows a nonfatal uncorrectable error to be treated as advisory, and the requester ID of the source. The block first filters the status code. It then sets the device-status detection bits and the correctable or uncorrectable status registers. Next it applies the mask and severity registers. From that it decides whether to ask the header-log unit to capture the header and whether to emit an error message with a one-hot severity code and source ID.

The header-log unit answers a log request in the same cycle with an overflow flag. When the log overflowed and the first event produced a message, the block holds off its input for one cycle. In that cycle it processes an internally generated correctable Header Log Overflow event. A small write port loads the masks, the severity register and the reporting enables. The same port also clears status bits by writing ones.

Top module: `aer_err_classifier`

## Requirements
- R1: Uncorrectable status codes are limited to bits 4,5,12-21,23,24,25 and correctable codes to bits 0,6,7,8,12,13,14,15. After `evt_status` is reduced to the supported set for its class, an event with zero or more than one bit left is ignored: no status bit changes, `hlog_req` stays low and no message is emitted.
- R2: After reset the severity register reads fatal for bits 4 (link protocol), 5 (surprise down), 13 (flow control protocol), 17 (receiver overflow) and 18 (malformed packet), and nonfatal for every other supported code. A written severity bit replaces that default. Message severities are one-hot: 1 correctable, 2 nonfatal, 4 fatal.
- R3: A correctable event sets `dev_sts[0]` (correctable detected) and its bit in `cor_sts`. If that bit is set in the correctable mask, no message follows. Otherwise a severity-1 message is sent only when control bit 0 (correctable reporting) is set.
- R4: An uncorrectable event sets `dev_sts[2]` if it is fatal or `dev_sts[1]` if it is nonfatal, and always sets its bit in `unc_sts`. If that bit is set in the uncorrectable mask, there is no header-log request and no message.
- R5: An unmasked fatal event sends a severity-4 message only if control bit 4 (system error enable) or bit 2 (fatal reporting) is set. An unmasked nonfatal event sends a severity-2 message only if bit 4 or bit 1 (nonfatal reporting) is set.
- R6: An uncorrectable Unsupported Request (bit 20) also sets `dev_sts[3]`. Handled as uncorrectable, it sends nothing when both control bit 3 (UR reporting) and bit 4 are clear. Rerouted as advisory, it sends nothing unless bit 3 is set.
- R7: A nonfatal uncorrectable event flagged advisory is handled as a correctable event with code bit 13. It sets `dev_sts[0]` and `cor_sts[13]`. When bit 13 is unmasked in the correctable mask, it also sets its own bit in `unc_sts` and raises `hlog_req` if that bit is unmasked in the uncorrectable mask. A masked bit 13 stops all further handling.
- R8: `hlog_req` is asserted combinationally in the acceptance cycle exactly for events that reach logging. `hlog_ovf` is sampled in that same cycle.
- R9: When a logged event overflowed the header log and produced a message, `evt_ready` is low for the next cycle. In that cycle a correctable event with code bit 15 and the same source ID is processed, and its message (if any) follows the first by one cycle.
- R10: A message appears on `msg_valid`/`msg_sev`/`msg_src` in the cycle after the event is processed and lasts one cycle.
- R11: Write port selects: 0 uncorrectable mask, 1 severity, 2 correctable mask, 3 control (bits 4:0), 4/5/6 write-one-to-clear of `unc_sts`/`cor_sts`/`dev_sts`. A status bit set by an event in the same cycle as a clear stays set. Masks, control and status reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event present |
| evt_ready | output | 1 | Event accepted when high with evt_valid |
| evt_status | input | 32 | Error status code (one bit expected) |
| evt_corr | input | 1 | Event is correctable |
| evt_adv | input | 1 | Event may be handled as advisory |
| evt_src | input | SRC_W | Requester ID of the event |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| hlog_req | output | 1 | Header capture request |
| hlog_ovf | input | 1 | Header log overflowed on this request |
| msg_valid | output | 1 | Error message emitted |
| msg_sev | output | 3 | One-hot message severity |
| msg_src | output | SRC_W | Message source ID |
| unc_sts | output | 32 | Uncorrectable status register |
| cor_sts | output | 32 | Correctable status register |
| dev_sts | output | 4 | Device-status detection bits |

## Verification
Some properties are checked on every cycle. A message always carries exactly one severity bit. A fatal message is never emitted without the fatal-detected bit. Every newly set correctable status bit comes with the correctable-detected bit. The ready gap lasts one cycle, follows an overflowed log request, and leaves the overflow status bit set. Other behaviour is shown only by the bench scenarios: the gating of messages by the enables, masks and severity, the advisory rerouting, the Unsupported Request special cases and the rejection of malformed codes. These need a model of the register contents across many events.

// File: rtl/aer_cls_pkg.sv
`timescale 1ns/1ps
package aer_cls_pkg;
  localparam int STS_W = 32;
  localparam int DEV_W = 4;
  localparam int CTL_W = 5;

  localparam logic [STS_W-1:0] UNC_SUPPORTED     = 32'h03BF_F030;
  localparam logic [STS_W-1:0] UNC_FATAL_DEFAULT = 32'h0006_2030;
  localparam logic [STS_W-1:0] UNC_UR_BIT        = 32'h0010_0000;
  localparam logic [STS_W-1:0] COR_SUPPORTED     = 32'h0000_F1C1;
  localparam logic [STS_W-1:0] COR_ADVISORY_BIT  = 32'h0000_2000;
  localparam logic [STS_W-1:0] COR_HDR_OVF_BIT   = 32'h0000_8000;

  localparam int DS_COR = 0;
  localparam int DS_NF  = 1;
  localparam int DS_FAT = 2;
  localparam int DS_UR  = 3;

  localparam int CT_COR  = 0;
  localparam int CT_NF   = 1;
  localparam int CT_FAT  = 2;
  localparam int CT_UR   = 3;
  localparam int CT_SERR = 4;

  typedef enum logic [2:0] {
    SEV_NONE = 3'd0,
    SEV_COR  = 3'd1,
    SEV_NF   = 3'd2,
    SEV_FAT  = 3'd4
  } sev_e;

  typedef enum logic [2:0] {
    SEL_UMASK = 3'd0,
    SEL_USEV  = 3'd1,
    SEL_CMASK = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_USTS  = 3'd4,
    SEL_CSTS  = 3'd5,
    SEL_DSTS  = 3'd6
  } sel_e;

  typedef struct packed {
    logic [STS_W-1:0] unc_mask;
    logic [STS_W-1:0] unc_sev;
    logic [STS_W-1:0] cor_mask;
    logic [CTL_W-1:0] ctrl;
  } cfg_t;

  typedef struct packed {
    logic [DEV_W-1:0] dev_set;
    logic [STS_W-1:0] cor_set;
    logic [STS_W-1:0] unc_set;
    logic             log_req;
    logic             msg_en;
    sev_e             sev;
  } verdict_t;
endpackage

// File: rtl/aer_cls_cfg.sv
`timescale 1ns/1ps
module aer_cls_cfg
  import aer_cls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [STS_W-1:0] cfg_wdata,
  output cfg_t             cfg
);
  cfg_t cfg_q, cfg_d;
  logic cfg_en;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_UMASK: begin cfg_d.unc_mask = cfg_wdata & UNC_SUPPORTED; cfg_en = 1'b1; end
        SEL_USEV:  begin cfg_d.unc_sev  = cfg_wdata & UNC_SUPPORTED; cfg_en = 1'b1; end
        SEL_CMASK: begin cfg_d.cor_mask = cfg_wdata & COR_SUPPORTED; cfg_en = 1'b1; end
        SEL_CTRL:  begin cfg_d.ctrl     = cfg_wdata[CTL_W-1:0];      cfg_en = 1'b1; end
        default:   cfg_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.unc_mask <= '0;
      cfg_q.unc_sev  <= UNC_FATAL_DEFAULT;
      cfg_q.cor_mask <= '0;
      cfg_q.ctrl     <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/aer_cls_decide.sv
`timescale 1ns/1ps
module aer_cls_decide
  import aer_cls_pkg::*;
(
  input  logic [STS_W-1:0] status,
  input  logic             corr,
  input  logic             adv,
  input  cfg_t             cfg,
  output verdict_t         verdict
);
  logic [STS_W-1:0] code;
  logic [STS_W-1:0] cbit;
  logic             single;
  logic             is_ur;
  logic             fatal;
  logic             to_adv;

  always_comb begin
    code    = status & (corr ? COR_SUPPORTED : UNC_SUPPORTED);
    single  = (code != '0) && ((code & (code - 1'b1)) == '0);
    is_ur   = !corr && (code == UNC_UR_BIT);
    fatal   = !corr && ((code & cfg.unc_sev) != '0);
    to_adv  = !corr && !fatal && adv;
    cbit    = corr ? code : COR_ADVISORY_BIT;
    verdict = '0;
    if (single) begin
      if (corr || to_adv) begin
        verdict.dev_set[DS_COR] = 1'b1;
        verdict.dev_set[DS_UR]  = is_ur;
        verdict.cor_set         = cbit;
        if ((cfg.cor_mask & cbit) == '0) begin
          if (to_adv) begin
            verdict.unc_set = code;
            verdict.log_req = (cfg.unc_mask & code) == '0;
          end
          verdict.msg_en = cfg.ctrl[CT_COR] && !(is_ur && !cfg.ctrl[CT_UR]);
          verdict.sev    = SEV_COR;
        end
      end else begin
        verdict.dev_set[DS_FAT] = fatal;
        verdict.dev_set[DS_NF]  = !fatal;
        verdict.dev_set[DS_UR]  = is_ur;
        verdict.unc_set         = code;
        if ((cfg.unc_mask & code) == '0) begin
          verdict.log_req = 1'b1;
          if (!(is_ur && !cfg.ctrl[CT_UR] && !cfg.ctrl[CT_SERR])) begin
            verdict.msg_en = cfg.ctrl[CT_SERR] ||
                             (fatal ? cfg.ctrl[CT_FAT] : cfg.ctrl[CT_NF]);
          end
          verdict.sev = fatal ? SEV_FAT : SEV_NF;
        end
      end
    end
  end
endmodule

// File: rtl/aer_cls_status.sv
`timescale 1ns/1ps
module aer_cls_status
  import aer_cls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  verdict_t         verdict,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [STS_W-1:0] cfg_wdata,
  output logic [STS_W-1:0] unc_sts,
  output logic [STS_W-1:0] cor_sts,
  output logic [DEV_W-1:0] dev_sts
);
  logic [STS_W-1:0] unc_q, unc_d, cor_q, cor_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic             sts_en;

  always_comb begin
    unc_d  = unc_q;
    cor_d  = cor_q;
    dev_d  = dev_q;
    sts_en = go;
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_USTS: begin unc_d = unc_q & ~cfg_wdata;            sts_en = 1'b1; end
        SEL_CSTS: begin cor_d = cor_q & ~cfg_wdata;            sts_en = 1'b1; end
        SEL_DSTS: begin dev_d = dev_q & ~cfg_wdata[DEV_W-1:0]; sts_en = 1'b1; end
        default:  ;
      endcase
    end
    if (go) begin
      unc_d = unc_d | verdict.unc_set;
      cor_d = cor_d | verdict.cor_set;
      dev_d = dev_d | verdict.dev_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unc_q <= '0;
      cor_q <= '0;
      dev_q <= '0;
    end else if (sts_en) begin
      unc_q <= unc_d;
      cor_q <= cor_d;
      dev_q <= dev_d;
    end
  end

  assign unc_sts = unc_q;
  assign cor_sts = cor_q;
  assign dev_sts = dev_q;
endmodule

// File: rtl/aer_err_classifier.sv
`timescale 1ns/1ps
module aer_err_classifier
  import aer_cls_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [31:0]      evt_status,
  input  logic             evt_corr,
  input  logic             evt_adv,
  input  logic [SRC_W-1:0] evt_src,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             hlog_req,
  input  logic             hlog_ovf,
  output logic             msg_valid,
  output logic [2:0]       msg_sev,
  output logic [SRC_W-1:0] msg_src,
  output logic [31:0]      unc_sts,
  output logic [31:0]      cor_sts,
  output logic [3:0]       dev_sts
);
  cfg_t             cfg;
  verdict_t         verdict;
  logic             accept, go;
  logic             pend_q, pend_d;
  logic [SRC_W-1:0] src_q, src_d, cur_src;
  logic [STS_W-1:0] cur_status;
  logic             cur_corr, cur_adv;
  logic             mv_d, mv_q;
  logic [2:0]       ms_d, ms_q;

  assign evt_ready = !pend_q;
  assign accept    = evt_valid && evt_ready;
  assign go        = accept || pend_q;

  always_comb begin
    if (pend_q) begin
      cur_status = COR_HDR_OVF_BIT;
      cur_corr   = 1'b1;
      cur_adv    = 1'b0;
      cur_src    = src_q;
    end else begin
      cur_status = evt_status;
      cur_corr   = evt_corr;
      cur_adv    = evt_adv;
      cur_src    = evt_src;
    end
  end

  aer_cls_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg(cfg)
  );

  aer_cls_decide u_decide (
    .status(cur_status), .corr(cur_corr), .adv(cur_adv),
    .cfg(cfg), .verdict(verdict)
  );

  aer_cls_status u_status (
    .clk(clk), .rst_n(rst_n), .go(go), .verdict(verdict),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .unc_sts(unc_sts), .cor_sts(cor_sts), .dev_sts(dev_sts)
  );

  assign hlog_req = accept && verdict.log_req;

  always_comb begin
    pend_d = hlog_req && hlog_ovf && verdict.msg_en;
    src_d  = pend_d ? evt_src : src_q;
    mv_d   = go && verdict.msg_en;
    ms_d   = mv_d ? verdict.sev : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mv_q   <= 1'b0;
      ms_q   <= '0;
    end else begin
      pend_q <= pend_d;
      mv_q   <= mv_d;
      ms_q   <= ms_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      msg_src <= '0;
    end else begin
      if (pend_d) src_q <= src_d;
      if (mv_d)   msg_src <= cur_src;
    end
  end

  assign msg_valid = mv_q;
  assign msg_sev   = ms_q;
endmodule

// File: rtl/aer_err_classifier_chk.sv
`timescale 1ns/1ps
module aer_err_classifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_ready,
  input logic        hlog_req,
  input logic        hlog_ovf,
  input logic        msg_valid,
  input logic [2:0]  msg_sev,
  input logic [31:0] cor_sts,
  input logic [3:0]  dev_sts
);
  a_r2_sev_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $countones(msg_sev) == 1);

  a_r4_fatal_detected: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 3'd4) |-> dev_sts[2]);

  a_r3_cor_detected: assert property (@(posedge clk) disable iff (!rst_n)
    ((cor_sts & ~$past(cor_sts)) != 32'd0) |-> dev_sts[0]);

  a_r9_gap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |-> $past(hlog_req && hlog_ovf));

  a_r9_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |=> evt_ready);

  a_r9_ovf_status: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_ready |=> cor_sts[15]);

  a_r8_no_log_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    hlog_req |-> evt_ready);
endmodule

bind aer_err_classifier aer_err_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_ready(evt_ready), .hlog_req(hlog_req),
  .hlog_ovf(hlog_ovf), .msg_valid(msg_valid), .msg_sev(msg_sev),
  .cor_sts(cor_sts), .dev_sts(dev_sts)
);

// File: tb/aer_err_classifier_tb.sv
`timescale 1ns/1ps
module aer_err_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [31:0] evt_status = '0;
  logic        evt_corr = 1'b0;
  logic        evt_adv = 1'b0;
  logic [15:0] evt_src = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hlog_req;
  logic        hlog_ovf = 1'b0;
  logic        msg_valid;
  logic [2:0]  msg_sev;
  logic [15:0] msg_src;
  logic [31:0] unc_sts, cor_sts;
  logic [3:0]  dev_sts;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // bench model of register contents
  logic [31:0] m_umask, m_usev, m_cmask, m_usts, m_csts;
  logic [4:0]  m_ctrl;
  logic [3:0]  m_dsts;

  localparam logic [31:0] K_UNC = 32'h03BF_F030;
  localparam logic [31:0] K_COR = 32'h0000_F1C1;

  always #2.5 clk = ~clk;

  aer_err_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_status(evt_status), .evt_corr(evt_corr), .evt_adv(evt_adv),
    .evt_src(evt_src), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hlog_req(hlog_req), .hlog_ovf(hlog_ovf), .msg_valid(msg_valid),
    .msg_sev(msg_sev), .msg_src(msg_src), .unc_sts(unc_sts), .cor_sts(cor_sts),
    .dev_sts(dev_sts)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected handling of one event; updates model status
  task automatic model(input logic [31:0] raw, input bit corr, input bit adv,
                       output bit lg, output bit ms, output logic [2:0] sv);
    logic [31:0] st, cb;
    bit ur, fat;
    st = raw & (corr ? K_COR : K_UNC);
    lg = 0; ms = 0; sv = 3'd0;
    if ($countones(st) != 1) return;
    ur  = !corr && st == 32'h0010_0000;
    fat = !corr && (m_usev & st) != 0;
    if (corr || (!fat && adv)) begin
      cb = corr ? st : 32'h0000_2000;
      m_dsts = m_dsts | 4'b0001 | (ur ? 4'b1000 : 4'b0000);
      m_csts = m_csts | cb;
      if ((m_cmask & cb) != 0) return;
      if (!corr) begin
        lg = (m_umask & st) == 0;
        m_usts = m_usts | st;
      end
      if (ur && !m_ctrl[3]) return;
      if (!m_ctrl[0]) return;
      ms = 1; sv = 3'd1;
    end else begin
      m_dsts = m_dsts | (fat ? 4'b0100 : 4'b0010) | (ur ? 4'b1000 : 4'b0000);
      m_usts = m_usts | st;
      if ((m_umask & st) != 0) return;
      lg = 1;
      if (ur && !m_ctrl[3] && !m_ctrl[4]) return;
      ms = m_ctrl[4] || (fat ? m_ctrl[2] : m_ctrl[1]);
      if (ms) sv = fat ? 3'd4 : 3'd2;
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      3'd0: m_umask = d & K_UNC;
      3'd1: m_usev  = d & K_UNC;
      3'd2: m_cmask = d & K_COR;
      3'd3: m_ctrl  = d[4:0];
      3'd4: m_usts  = m_usts & ~d;
      3'd5: m_csts  = m_csts & ~d;
      3'd6: m_dsts  = m_dsts & ~d[3:0];
      default: ;
    endcase
    check(unc_sts == m_usts && cor_sts == m_csts, "R11 write port", unc_sts ^ cor_sts,
          m_usts ^ m_csts);
  endtask

  task automatic check_state(input string req);
    check(unc_sts == m_usts, req, unc_sts, m_usts);
    check(cor_sts == m_csts, req, cor_sts, m_csts);
    check(dev_sts == m_dsts, req, {28'd0, dev_sts}, {28'd0, m_dsts});
  endtask

  task automatic send(input logic [31:0] st, input bit corr, input bit adv,
                      input logic [15:0] src, input bit ovf, input string req);
    bit lg, ms, chain, lg2, ms2;
    logic [2:0] sv, sv2;
    @(negedge clk);
    evt_valid = 1; evt_status = st; evt_corr = corr; evt_adv = adv;
    evt_src = src; hlog_ovf = ovf;
    model(st, corr, adv, lg, ms, sv);
    chain = lg && ovf && ms;
    #1;
    check(hlog_req == lg, {req, " R8 hlog_req"}, {31'd0, hlog_req}, {31'd0, lg});
    @(posedge clk);
    @(negedge clk);
    evt_valid = 0; hlog_ovf = 0;
    check(msg_valid == ms, {req, " R10 msg_valid"}, {31'd0, msg_valid}, {31'd0, ms});
    if (ms) begin
      check(msg_sev == sv, {req, " R2 msg_sev"}, {29'd0, msg_sev}, {29'd0, sv});
      check(msg_src == src, {req, " R10 msg_src"}, {16'd0, msg_src}, {16'd0, src});
    end
    check_state(req);
    check(evt_ready == !chain, {req, " R9 ready"}, {31'd0, evt_ready}, {31'd0, !chain});
    if (chain) begin
      model(32'h0000_8000, 1'b1, 1'b0, lg2, ms2, sv2);
      @(posedge clk);
      @(negedge clk);
      check(msg_valid == ms2, "R9 chained msg", {31'd0, msg_valid}, {31'd0, ms2});
      if (ms2) begin
        check(msg_sev == 3'd1, "R9 chained sev", {29'd0, msg_sev}, 32'd1);
        check(msg_src == src, "R9 chained src", {16'd0, msg_src}, {16'd0, src});
      end
      check_state("R9 chained status");
      check(evt_ready == 1'b1, "R9 ready back", {31'd0, evt_ready}, 32'd1);
    end
  endtask

  function automatic logic [31:0] pick_bit(input logic [31:0] sup);
    logic [31:0] b;
    b = 32'd0;
    while ((b & sup) == 0) b = 32'd1 << ($urandom % 32);
    return b;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_umask = '0; m_usev = 32'h0006_2030; m_cmask = '0; m_ctrl = '0;
    m_usts = '0; m_csts = '0; m_dsts = '0;
    #12 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check_state("R11 reset");
    check(msg_valid == 0 && evt_ready == 1, "R11 reset outputs",
          {30'd0, msg_valid, evt_ready}, 32'd1);

    // R2 default severities with system error enable
    cfg_write(3'd3, 32'h10);
    send(32'h0000_0010, 0, 0, 16'h0101, 0, "R2 fatal default");
    send(32'h0000_1000, 0, 0, 16'h0102, 0, "R2 nonfatal default");
    send(32'h0004_0000, 0, 1, 16'h0103, 0, "R2 fatal ignores adv");
    cfg_write(3'd1, 32'h0000_1000);
    send(32'h0000_1000, 0, 0, 16'h0104, 0, "R2 severity override");
    send(32'h0000_0010, 0, 0, 16'h0105, 0, "R2 severity override nf");
    cfg_write(3'd1, 32'h0006_2030);

    // R1 ignored codes
    send(32'h0000_3000, 0, 0, 16'h0201, 0, "R1 two bits");
    send(32'h0040_0000, 0, 0, 16'h0202, 0, "R1 unsupported bit");
    send(32'h0000_0002, 1, 0, 16'h0203, 0, "R1 unsupported cor");
    send(32'h0000_0000, 1, 0, 16'h0204, 0, "R1 zero");

    // R5 enables
    cfg_write(3'd3, 32'h00);
    send(32'h0000_2000, 0, 0, 16'h0301, 0, "R5 fatal disabled");
    cfg_write(3'd3, 32'h04);
    send(32'h0000_2000, 0, 0, 16'h0302, 0, "R5 fatal enable");
    send(32'h0000_4000, 0, 0, 16'h0303, 0, "R5 nf not enabled");
    cfg_write(3'd3, 32'h02);
    send(32'h0000_4000, 0, 0, 16'h0304, 0, "R5 nf enable");

    // R3 correctable and mask
    cfg_write(3'd3, 32'h01);
    send(32'h0000_0040, 1, 0, 16'h0401, 0, "R3 cor msg");
    cfg_write(3'd2, 32'h0000_0040);
    send(32'h0000_0040, 1, 0, 16'h0402, 0, "R3 cor masked");

    // R4 uncorrectable mask
    cfg_write(3'd3, 32'h10);
    cfg_write(3'd0, 32'h0000_8000);
    send(32'h0000_8000, 0, 0, 16'h0501, 1, "R4 unc masked");

    // R6 unsupported request gating
    cfg_write(3'd3, 32'h06);
    send(32'h0010_0000, 0, 0, 16'h0601, 0, "R6 UR blocked");
    cfg_write(3'd3, 32'h0E);
    send(32'h0010_0000, 0, 0, 16'h0602, 0, "R6 UR enabled");
    cfg_write(3'd3, 32'h01);
    send(32'h0010_0000, 0, 1, 16'h0603, 0, "R6 UR advisory blocked");
    cfg_write(3'd3, 32'h09);
    send(32'h0010_0000, 0, 1, 16'h0604, 0, "R6 UR advisory sent");

    // R7 advisory reroute
    send(32'h0001_0000, 0, 1, 16'h0701, 0, "R7 advisory");
    cfg_write(3'd2, 32'h0000_2000);
    send(32'h0000_1000, 0, 1, 16'h0702, 1, "R7 advisory masked");
    cfg_write(3'd2, 32'h0);

    // R9 overflow chain, then masked overflow bit
    cfg_write(3'd3, 32'h17);
    send(32'h0000_1000, 0, 0, 16'h0801, 1, "R9 chain nf");
    cfg_write(3'd2, 32'h0000_8000);
    send(32'h0000_0020, 0, 0, 16'h0802, 1, "R9 chain masked hlo");
    cfg_write(3'd3, 32'h00);
    send(32'h0000_0020, 0, 0, 16'h0803, 1, "R9 no msg no chain");

    // R11 clear
    cfg_write(3'd4, 32'hFFFF_FFFF);
    cfg_write(3'd5, 32'hFFFF_FFFF);
    cfg_write(3'd6, 32'hF);
    check_state("R11 cleared");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      bit c;
      logic [31:0] s;
      k = $urandom % 16;
      if (k == 0) cfg_write(3'd3, $urandom);
      else if (k == 1) cfg_write(3'($urandom % 3), $urandom & $urandom);
      else if (k == 2) cfg_write(3'(4 + $urandom % 3), $urandom);
      c = ($urandom % 3) == 0;
      if (($urandom % 8) == 0) s = $urandom;
      else s = pick_bit(c ? K_COR : K_UNC);
      send(s, c, $urandom % 2, 16'($urandom), $urandom % 2, "R3 R4 R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule